// File: doc/BRIEF.md
# Cut-off Measurement Line Sequencer

This block times the picture-tube cut-off regulation loop of a video output stage. It watches a line-rate horizontal pulse, the vertical blanking component and an optional vertical flyback pulse. Once per field, after vertical blanking, it opens four measurement lines. The first line measures tube leakage. The next three measure the cut-off of the red, green and blue channels, in that order. For each line it drives per-channel selects: ultra-black forcing and measurement-level drive. It also drives a leakage sample window, a brightness-disable flag and a global blanking flag. The analog measuring, storage and comparison sit outside the block, and their results come back as two plain digital inputs.

The measurement window opens on whichever vertical pulse ends first. Blanking lasts until the later of two points: the end of the vertical blanking component or the end of the last measurement line. A two-phase switch-on sequence comes ahead of normal operation. In the first phase, line scan is held at ultra-black and a white monitor pulse runs during vertical blanking. In the second phase, cut-off measurement runs but blanking is still held. A control bit can switch cut-off regulation off. In that mode the measurement lines become output clamp windows. All pins are plain level signals. There is no streaming data path, so no handshake applies. Every output changes one clock after the input sample that causes it.

Top module: `cutoff_seq`

## Requirements
- R1: While and after reset, with `cutoff_off` low, the block is in the first switch-on phase. With `v_blank` low, this gives `blank`=1, `chan_ub` all ones, and every other output 0.
- R2: The measurement lines follow one another on successive `h_pulse` rising edges. First the leakage line: `leak_win`=1 (when cut-off is enabled) and `chan_ub`=111. Then red: `chan_meas`=001 and `chan_ub`=110. Then green: 010/101. Then blue: 100/011. Bit 0 is red, bit 1 green and bit 2 blue. The next edge ends the sequence.
- R3: With `v_flyback` held high, the sequence is triggered by the falling edge of `v_blank`. An `h_pulse` rising edge in the trigger cycle belongs to the partial line and does not open a measurement line.
- R4: A falling edge of `v_flyback` while `v_blank` is still high triggers the sequence. The lines then start on the following `h_pulse` edges.
- R5: `blank` is high while `v_blank` is high, and also while a sequence is pending or running. It is released only when both have ended and the block is in normal operation.
- R6: `bright_off` is high throughout vertical blanking and throughout a pending or running sequence.
- R7: If `v_flyback` stays low through a field, no measurement line opens. `leak_win`, `clamp_win` and `chan_meas` stay 0, and blanking ends with `v_blank`.
- R8: With `cutoff_off`=1, the switch-on phases are skipped from the next clock. The measurement lines then carry `clamp_win`=1 with all channels at ultra-black, and `chan_meas` and `leak_win` stay 0.
- R9: In the first switch-on phase, `monitor` follows vertical blanking. No measurement drive or leakage window is issued.
- R10: When `warm_ok` goes high, the second phase begins: `monitor` stops, and measurement lines drive `chan_meas` and `leak_win`, while `blank` stays high. When `loop_settled` goes high, normal operation starts and `blank` is released.
- R11: A rising edge of `v_blank` during a sequence aborts it and re-arms the block. Once a sequence completes, no further trigger is accepted until the next `v_blank` rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_pulse | input | 1 | Line-rate horizontal pulse, synchronous |
| v_blank | input | 1 | Vertical blanking component |
| v_flyback | input | 1 | Optional vertical flyback pulse; held high when unused |
| cutoff_off | input | 1 | 1 = cut-off regulation off, outputs clamped |
| warm_ok | input | 1 | Cathode warm-up threshold reached |
| loop_settled | input | 1 | Cut-off loop has settled |
| blank | output | 1 | Blank all RGB outputs |
| bright_off | output | 1 | Disable brightness adjustment |
| chan_ub | output | NCH | Per-channel force to ultra-black (bit 0 red) |
| chan_meas | output | NCH | Per-channel drive to measurement level (bit 0 red) |
| leak_win | output | 1 | Leakage measurement line window |
| clamp_win | output | 1 | Output clamp window (cut-off off) |
| monitor | output | 1 | White-level monitor pulse during warm-up |

## Verification
A field with the flyback input held high exercises the blanking-edge trigger, including a horizontal edge that coincides with the trigger and must be skipped. A field whose flyback pulse ends before blanking shows that the earlier edge wins and that blanking outlasts the sequence. A held-low flyback input must produce no lines at all. A second blanking edge in mid-sequence must restart the cycle from the leakage line. Fields run in each switch-on phase and in clamp mode tell the monitor, measurement and clamp outputs apart on otherwise identical line timing.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [1:0] {PH_WARM1, PH_WARM2, PH_RUN} phase_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ARMED, SQ_WAIT, SQ_LINE} seq_t;
endpackage

// File: rtl/csq_edges.sv
module csq_edges #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl_q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= din[i];
    end
  end

  assign lvl_q = q;
  assign rise  = din & ~q;
  assign fall  = ~din & q;
endmodule

// File: rtl/csq_phase.sv
module csq_phase
  import csq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cutoff_off,
  input  logic   warm_ok,
  input  logic   loop_settled,
  output phase_t phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_WARM1;
    end else if (cutoff_off) begin
      phase <= PH_RUN;
    end else begin
      case (phase)
        PH_WARM1: if (warm_ok)      phase <= PH_WARM2;
        PH_WARM2: if (loop_settled) phase <= PH_RUN;
        default:  phase <= phase;
      endcase
    end
  end
endmodule

// File: rtl/csq_lines.sv
module csq_lines
  import csq_pkg::*;
#(
  parameter int NCH = 3,
  localparam int IW = $clog2(NCH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_rise,
  input  logic          vb_rise,
  input  logic          vb_fall,
  input  logic          fb_fall,
  input  logic          fb_lvl,
  output logic          in_line,
  output logic          busy,
  output logic [IW-1:0] line_idx
);
  localparam logic [IW-1:0] LAST = IW'(NCH);

  seq_t st;
  logic trig;

  // earlier of the two trailing edges; a held-low flyback never triggers
  assign trig = fb_fall | (vb_fall & fb_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      line_idx <= '0;
    end else if (vb_rise) begin
      st       <= SQ_ARMED;
      line_idx <= '0;
    end else begin
      case (st)
        SQ_ARMED: if (trig) st <= SQ_WAIT;
        SQ_WAIT: if (h_rise) begin
          st       <= SQ_LINE;
          line_idx <= '0;
        end
        SQ_LINE: if (h_rise) begin
          if (line_idx == LAST) st <= SQ_IDLE;
          else                  line_idx <= line_idx + 1'b1;
        end
        default: st <= st;
      endcase
    end
  end

  assign in_line = (st == SQ_LINE);
  assign busy    = (st == SQ_WAIT) || (st == SQ_LINE);
endmodule

// File: rtl/cutoff_seq.sv
module cutoff_seq
  import csq_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_pulse,
  input  logic           v_blank,
  input  logic           v_flyback,
  input  logic           cutoff_off,
  input  logic           warm_ok,
  input  logic           loop_settled,
  output logic           blank,
  output logic           bright_off,
  output logic [NCH-1:0] chan_ub,
  output logic [NCH-1:0] chan_meas,
  output logic           leak_win,
  output logic           clamp_win,
  output logic           monitor
);
  localparam int IW = $clog2(NCH + 1);
  localparam int H  = 0;
  localparam int VB = 1;
  localparam int FB = 2;

  logic [2:0]    lvl_q, rise, fall;
  logic          in_line, busy, cut_en, vb_q, warm1;
  logic [IW-1:0] line_idx;
  phase_t        phase;
  logic          edge_unused;

  csq_edges #(.W(3)) u_edges (
    .clk(clk), .rst_n(rst_n), .din({v_flyback, v_blank, h_pulse}),
    .lvl_q(lvl_q), .rise(rise), .fall(fall)
  );

  csq_phase u_phase (
    .clk(clk), .rst_n(rst_n), .cutoff_off(cutoff_off),
    .warm_ok(warm_ok), .loop_settled(loop_settled), .phase(phase)
  );

  csq_lines #(.NCH(NCH)) u_lines (
    .clk(clk), .rst_n(rst_n), .h_rise(rise[H]), .vb_rise(rise[VB]),
    .vb_fall(fall[VB]), .fb_fall(fall[FB]), .fb_lvl(v_flyback),
    .in_line(in_line), .busy(busy), .line_idx(line_idx)
  );

  assign edge_unused = ^{lvl_q[H], lvl_q[FB], fall[H], rise[FB]};

  assign vb_q   = lvl_q[VB];
  assign warm1  = (phase == PH_WARM1);
  assign cut_en = !warm1 && !cutoff_off;

  assign blank      = vb_q | busy | (phase != PH_RUN);
  assign bright_off = vb_q | busy;
  assign monitor    = warm1 & vb_q;
  assign leak_win   = in_line && cut_en && (line_idx == '0);
  assign clamp_win  = in_line && cutoff_off;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign chan_meas[c] = in_line && cut_en && (line_idx == IW'(c + 1));
    assign chan_ub[c]   = in_line ? !chan_meas[c] : (warm1 && !vb_q);
  end
endmodule

// File: rtl/csq_chk.sv
module csq_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           v_blank,
  input logic           v_flyback,
  input logic           cutoff_off,
  input logic           blank,
  input logic           bright_off,
  input logic [NCH-1:0] chan_ub,
  input logic [NCH-1:0] chan_meas,
  input logic           leak_win,
  input logic           clamp_win,
  input logic           monitor
);
  logic fb_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fb_seen <= 1'b0;
    else if (v_flyback) fb_seen <= 1'b1;
  end

  // R2
  meas_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_meas) && ((chan_meas & chan_ub) == '0));

  // R5
  lines_blanked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (leak_win || clamp_win || (chan_meas != '0)) |-> (blank && bright_off));

  // R6
  vblank_bright_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(v_blank)) |-> bright_off);

  // R7
  no_flyback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_seen |-> !(leak_win || clamp_win || (chan_meas != '0)));

  // R8
  clamp_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cutoff_off |-> (chan_meas == '0 && !leak_win && !monitor));

  // R9
  monitor_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    monitor |-> (chan_meas == '0 && !leak_win && blank));
endmodule

bind cutoff_seq csq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .v_blank(v_blank), .v_flyback(v_flyback),
  .cutoff_off(cutoff_off), .blank(blank), .bright_off(bright_off),
  .chan_ub(chan_ub), .chan_meas(chan_meas), .leak_win(leak_win),
  .clamp_win(clamp_win), .monitor(monitor)
);

// File: tb/cutoff_seq_test.sv
`timescale 1ns/1ps
module cutoff_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_pulse = 1'b0, v_blank = 1'b0, v_flyback = 1'b1;
  logic cutoff_off = 1'b0, warm_ok = 1'b0, loop_settled = 1'b0;
  logic blank, bright_off, leak_win, clamp_win, monitor;
  logic [2:0] chan_ub, chan_meas;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cutoff_seq uut (
    .clk(clk), .rst_n(rst_n), .h_pulse(h_pulse), .v_blank(v_blank),
    .v_flyback(v_flyback), .cutoff_off(cutoff_off), .warm_ok(warm_ok),
    .loop_settled(loop_settled), .blank(blank), .bright_off(bright_off),
    .chan_ub(chan_ub), .chan_meas(chan_meas), .leak_win(leak_win),
    .clamp_win(clamp_win), .monitor(monitor)
  );

  // {blank, bright_off, ub[2:0], meas[2:0], leak, clamp, monitor}
  function automatic logic [10:0] mk(input logic b, input logic bo,
      input logic [2:0] ub, input logic [2:0] m, input logic l,
      input logic c, input logic mo);
    return {b, bo, ub, m, l, c, mo};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [10:0] exp);
    logic [10:0] act;
    act = {blank, bright_off, chan_ub, chan_meas, leak_win, clamp_win, monitor};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic hline(input string req, input logic [10:0] exp);
    h_pulse = 1'b1;
    cyc(1);
    h_pulse = 1'b0;
    check(req, exp);
    cyc(2);
  endtask

  task automatic t_reset;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    check("R1 reset state", mk(1,0,3'b111,3'b000,0,0,0));
  endtask

  task automatic t_warmup;
    v_blank = 1'b1; cyc(1);
    check("R9 monitor in vblank", mk(1,1,3'b000,3'b000,0,0,1));
    v_blank = 1'b0; cyc(1);
    check("R9 scan ultra-black", mk(1,1,3'b111,3'b000,0,0,0));
    hline("R9 no leak window", mk(1,1,3'b111,3'b000,0,0,0));
    hline("R9 no meas drive", mk(1,1,3'b111,3'b000,0,0,0));
    hline("R9 green line", mk(1,1,3'b111,3'b000,0,0,0));
    hline("R9 blue line", mk(1,1,3'b111,3'b000,0,0,0));
    hline("R9 sequence end", mk(1,0,3'b111,3'b000,0,0,0));
    warm_ok = 1'b1; cyc(1); warm_ok = 1'b0;
    check("R10 second phase", mk(1,0,3'b000,3'b000,0,0,0));
    v_blank = 1'b1; cyc(1);
    check("R10 monitor stopped", mk(1,1,3'b000,3'b000,0,0,0));
    v_blank = 1'b0; cyc(1);
    hline("R10 leak line", mk(1,1,3'b111,3'b000,1,0,0));
    hline("R10 red line", mk(1,1,3'b110,3'b001,0,0,0));
    hline("R10 green line", mk(1,1,3'b101,3'b010,0,0,0));
    hline("R10 blue line", mk(1,1,3'b011,3'b100,0,0,0));
    hline("R10 still blanked", mk(1,0,3'b000,3'b000,0,0,0));
    loop_settled = 1'b1; cyc(1);
    check("R10 blank released", mk(0,0,3'b000,3'b000,0,0,0));
  endtask

  task automatic t_order_no_fb;
    v_blank = 1'b1; cyc(2);
    check("R5 R6 vblank", mk(1,1,3'b000,3'b000,0,0,0));
    v_blank = 1'b0; h_pulse = 1'b1; cyc(1); h_pulse = 1'b0;
    check("R3 partial line skipped", mk(1,1,3'b000,3'b000,0,0,0));
    cyc(2);
    hline("R2 R3 leak line", mk(1,1,3'b111,3'b000,1,0,0));
    hline("R2 red line", mk(1,1,3'b110,3'b001,0,0,0));
    hline("R2 green line", mk(1,1,3'b101,3'b010,0,0,0));
    hline("R2 blue line", mk(1,1,3'b011,3'b100,0,0,0));
    hline("R2 R5 end released", mk(0,0,3'b000,3'b000,0,0,0));
  endtask

  task automatic t_fb_first;
    v_blank = 1'b1; cyc(2);
    v_flyback = 1'b0; cyc(1);
    hline("R4 leak line in vblank", mk(1,1,3'b111,3'b000,1,0,0));
    hline("R4 red line", mk(1,1,3'b110,3'b001,0,0,0));
    hline("R4 green line", mk(1,1,3'b101,3'b010,0,0,0));
    hline("R4 blue line", mk(1,1,3'b011,3'b100,0,0,0));
    hline("R5 held by vblank", mk(1,1,3'b000,3'b000,0,0,0));
    v_blank = 1'b0; cyc(1);
    check("R5 vblank end releases", mk(0,0,3'b000,3'b000,0,0,0));
    v_flyback = 1'b1; cyc(1);
    hline("R11 one sequence per field", mk(0,0,3'b000,3'b000,0,0,0));
  endtask

  task automatic t_abort;
    v_blank = 1'b1; cyc(1);
    v_blank = 1'b0; cyc(1);
    hline("R11 leak line", mk(1,1,3'b111,3'b000,1,0,0));
    hline("R11 red line", mk(1,1,3'b110,3'b001,0,0,0));
    v_blank = 1'b1; cyc(1);
    check("R11 aborted", mk(1,1,3'b000,3'b000,0,0,0));
    v_blank = 1'b0; cyc(1);
    hline("R11 restart at leak", mk(1,1,3'b111,3'b000,1,0,0));
    hline("R11 red again", mk(1,1,3'b110,3'b001,0,0,0));
    hline("R11 green", mk(1,1,3'b101,3'b010,0,0,0));
    hline("R11 blue", mk(1,1,3'b011,3'b100,0,0,0));
    hline("R11 end", mk(0,0,3'b000,3'b000,0,0,0));
  endtask

  task automatic t_fb_low;
    v_flyback = 1'b0; cyc(1);
    v_blank = 1'b1; cyc(1);
    v_blank = 1'b0; cyc(1);
    check("R7 no blanking extension", mk(0,0,3'b000,3'b000,0,0,0));
    for (int i = 0; i < 5; i++)
      hline("R7 no line", mk(0,0,3'b000,3'b000,0,0,0));
    v_flyback = 1'b1; cyc(1);
  endtask

  task automatic t_clamp;
    rst_n = 1'b0; cutoff_off = 1'b1; loop_settled = 1'b0; cyc(2);
    rst_n = 1'b1; cyc(1);
    check("R8 warm-up skipped", mk(0,0,3'b000,3'b000,0,0,0));
    v_blank = 1'b1; cyc(1);
    v_blank = 1'b0; cyc(1);
    hline("R8 clamp on leak line", mk(1,1,3'b111,3'b000,0,1,0));
    hline("R8 clamp on red line", mk(1,1,3'b111,3'b000,0,1,0));
    hline("R8 green", mk(1,1,3'b111,3'b000,0,1,0));
    hline("R8 blue", mk(1,1,3'b111,3'b000,0,1,0));
    hline("R8 end", mk(0,0,3'b000,3'b000,0,0,0));
    cutoff_off = 1'b0;
  endtask

  initial begin
    t_reset();
    t_warmup();
    t_order_no_fb();
    t_fb_first();
    t_abort();
    t_fb_low();
    t_clamp();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule